// File: doc/BRIEF.md
# Vectored Interrupt Source Router

This block takes seven level-sensitive interrupt inputs and folds them onto six vector registers. Each vector register carries a destination server number, a priority and a three-bit source index, and the source index picks which of eight output lines the vector drives. Two of the inputs (a link interrupt and a service-processor interrupt) share vector 0. Each of the other five inputs owns one vector. The block records a status bit per input, reports a pending flag in every vector, and keeps a source-compare register whose compare field supplies a source-number offset to the downstream presenter.

Software reaches all registers through a single-cycle register port. Writes take effect at the next clock edge and reads are combinational. A separate selector port shows the routing fields of one vector (server with its link-pointer bits removed, priority and source) for the downstream presenter. End-of-interrupt handling belongs to the presenter, not here.

Top module: `vec_irq_router`

## Requirements
- R1: After reset, vector i (i = 0..5) reads as priority 0xFF in bits 39:32, source i in bits 31:29, server 0 and pending 0. All output lines are low, the status words read 0, and the compare register reads 0.
- R2: An asserted input sets its status bit one clock later, and a released input clears it one clock later. Inputs 0 and 1 report in bits 47 and 46 of the control word at index 0x0E. Inputs 2, 3, 4, 5 and 6 report in bits 36, 35, 34, 33 and 32 of the status word at index 0x15.
- R3: While a vector's effective state is set, the output line numbered by that vector's source field is high. A line that no asserted vector selects is low.
- R4: The effective state of vector 0 is the OR of the status bits of inputs 0 and 1. Its line stays high until both of those status bits are clear.
- R5: Bit 24 (pending) of a vector read equals the effective state AND (priority != 0xFF).
- R6: A write to a vector (indices 0x10, 0x16, 0x17, 0x18, 0x19, 0x1A for vectors 0 to 5) stores only server 55:40, priority 39:32 and source 31:29. All other bits read 0, apart from the derived pending bit.
- R7: route_server, route_prio and route_src show server >> 2, the priority and the source of the vector chosen by route_sel. They read 0 when route_sel is 6 or 7.
- R8: A vector write with source field 7 pulses wr_err for one cycle after the write edge and leaves that vector unchanged.
- R9: A write to index 0x1B keeps bits 63:45 (compare) and 35:32 and zeroes the rest. src_offset shows the compare field. The stored bits do not change the output lines.
- R10: A read of an index that holds no register returns all ones. Writes to the control and status words are ignored.
- R11: Rewriting a vector's source field moves its asserted state to the newly selected line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 7 | Interrupt input levels, index 0..6 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register index |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr |
| route_sel | input | 3 | Vector whose routing fields are shown |
| route_server | output | 14 | Server of the selected vector without the link-pointer bits |
| route_prio | output | 8 | Priority of the selected vector |
| route_src | output | 3 | Source field of the selected vector |
| line_out | output | 8 | Interrupt output lines |
| src_offset | output | 19 | Compare field of the source-compare register |
| wr_err | output | 1 | One-cycle flag for a rejected vector write |

## Verification
The routing is first exercised with every single input alone, which shows whether each input reaches its own status bit and line. Both shared inputs together and a sparse mix of inputs then show that OR-merging happens only on vector 0. Directed sequences release the shared inputs one at a time, which separates a correct "both clear" release from a "last write wins" one. Mask toggling with an input held, and a remap of one vector to an unused line, separate the derived pending bit and the line selection from fixed wiring.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  localparam int DW        = 64;
  localparam int AW        = 6;
  localparam int NUM_IN    = 7;
  localparam int NUM_VEC   = 6;
  localparam int NUM_LINES = 8;
  localparam int SRC_W     = 3;
  localparam int SRV_W     = 16;
  localparam int PRI_W     = 8;
  localparam int CMP_W     = 19;
  localparam int SRC_LIMIT = 7;

  // vector field positions
  localparam int SRV_LO  = 40;
  localparam int PRI_LO  = 32;
  localparam int SRC_LO  = 29;
  localparam int PEND_B  = 24;
  // compare register positions
  localparam int CMP_LO  = 45;
  localparam int KEEP_HI = 35;
  localparam int KEEP_LO = 32;
  // status positions
  localparam int CTRL_B0 = 47;
  localparam int STAT_HI = 36;

  localparam logic [AW-1:0] A_CTRL = 6'h0E;
  localparam logic [AW-1:0] A_STAT = 6'h15;
  localparam logic [AW-1:0] A_VEC0 = 6'h10;
  localparam logic [AW-1:0] A_VEC1 = 6'h16;
  localparam logic [AW-1:0] A_CMP  = 6'h1B;

  typedef struct packed {
    logic [SRV_W-1:0] server;
    logic [PRI_W-1:0] prio;
    logic [SRC_W-1:0] src;
  } vec_t;

  function automatic vec_t vec_unpack(logic [DW-1:0] d);
    vec_t v;
    v.server = d[SRV_LO +: SRV_W];
    v.prio   = d[PRI_LO +: PRI_W];
    v.src    = d[SRC_LO +: SRC_W];
    return v;
  endfunction

  function automatic logic [DW-1:0] vec_pack(vec_t v, logic pend);
    logic [DW-1:0] d;
    d = '0;
    d[SRV_LO +: SRV_W] = v.server;
    d[PRI_LO +: PRI_W] = v.prio;
    d[SRC_LO +: SRC_W] = v.src;
    d[PEND_B]          = pend;
    return d;
  endfunction

  // returns {hit, index}
  function automatic logic [SRC_W:0] vec_slot(logic [AW-1:0] a);
    logic [AW-1:0] d;
    d = a - A_VEC1;
    if (a == A_VEC0) return {1'b1, {SRC_W{1'b0}}};
    if (a >= A_VEC1 && d < AW'(NUM_VEC - 1)) return {1'b1, d[SRC_W-1:0] + SRC_W'(1)};
    return '0;
  endfunction

  function automatic logic [SRV_W-3:0] srv_strip(logic [SRV_W-1:0] s);
    return s[SRV_W-1:2];
  endfunction

  function automatic logic is_masked(logic [PRI_W-1:0] p);
    return &p;
  endfunction
endpackage

// File: rtl/vsr_status.sv
module vsr_status
  import vsr_pkg::*;
#(
  parameter int N_IN  = NUM_IN,
  parameter int N_VEC = NUM_VEC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  irq_in,
  output logic [N_IN-1:0]  status,
  output logic [N_VEC-1:0] eff
);
  logic live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      live   <= 1'b0;
    end else begin
      status <= irq_in;
      live   <= 1'b1;
    end
  end

  // vector 0 merges the two shared inputs, the rest map one to one
  assign eff[0] = status[0] | status[1];
  for (genvar g = 1; g < N_VEC; g++) begin : g_eff
    assign eff[g] = status[g+1];
  end

  AST_STATUS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> (status == $past(irq_in))); // R2
endmodule

// File: rtl/vsr_vec_reg.sv
module vsr_vec_reg
  import vsr_pkg::*;
#(
  parameter int IDX   = 0,
  parameter int LIMIT = SRC_LIMIT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  vec_t wr_val,
  output vec_t vec,
  output logic bad_src
);
  assign bad_src = wr_hit && (int'(wr_val.src) >= LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec.server <= '0;
      vec.prio   <= '1;
      vec.src    <= SRC_W'(IDX);
    end else if (wr_hit && !bad_src) begin
      vec <= wr_val;
    end
  end

  AST_BAD_SRC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    bad_src |=> $stable(vec)); // R8
endmodule

// File: rtl/vsr_line_router.sv
module vsr_line_router
  import vsr_pkg::*;
#(
  parameter int N_VEC   = NUM_VEC,
  parameter int N_LINES = NUM_LINES,
  parameter int SW      = SRC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_VEC-1:0]    eff,
  input  logic [N_VEC*SW-1:0] src_flat,
  output logic [N_LINES-1:0]  line_out
);
  always_comb begin
    line_out = '0;
    for (int v = 0; v < N_VEC; v++) begin
      if (eff[v]) line_out[src_flat[v*SW +: SW]] = 1'b1;
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (eff == '0) |-> (line_out == '0)); // R3
endmodule

// File: rtl/vec_irq_router.sv
module vec_irq_router
  import vsr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IN-1:0]    irq_in,
  input  logic                 reg_we,
  input  logic [AW-1:0]        reg_addr,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  input  logic [SRC_W-1:0]     route_sel,
  output logic [SRV_W-3:0]     route_server,
  output logic [PRI_W-1:0]     route_prio,
  output logic [SRC_W-1:0]     route_src,
  output logic [NUM_LINES-1:0] line_out,
  output logic [CMP_W-1:0]     src_offset,
  output logic                 wr_err
);
  localparam int N_STAT = NUM_IN - 2;

  logic [NUM_IN-1:0]        status;
  logic [NUM_VEC-1:0]       eff;
  logic [NUM_VEC-1:0]       pend;
  logic [NUM_VEC-1:0]       bad;
  logic [NUM_VEC*SRC_W-1:0] src_flat;
  vec_t                     vecs [NUM_VEC];
  vec_t                     wr_val;
  logic [SRC_W:0]           slot;
  logic [DW-1:0]            cmp_q;
  logic [DW-1:0]            ctrl_word;
  logic [DW-1:0]            stat_word;

  assign slot   = vec_slot(reg_addr);
  assign wr_val = vec_unpack(reg_wdata);

  vsr_status #(.N_IN(NUM_IN), .N_VEC(NUM_VEC)) u_status (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .status(status), .eff(eff)
  );

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
    vsr_vec_reg #(.IDX(g), .LIMIT(SRC_LIMIT)) u_vec (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(reg_we && slot[SRC_W] && (slot[SRC_W-1:0] == SRC_W'(g))),
      .wr_val(wr_val), .vec(vecs[g]), .bad_src(bad[g])
    );
    assign pend[g] = eff[g] && !is_masked(vecs[g].prio);
    assign src_flat[g*SRC_W +: SRC_W] = vecs[g].src;
  end

  vsr_line_router #(.N_VEC(NUM_VEC), .N_LINES(NUM_LINES), .SW(SRC_W)) u_route (
    .clk(clk), .rst_n(rst_n), .eff(eff), .src_flat(src_flat), .line_out(line_out)
  );

  // source-compare register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else if (reg_we && reg_addr == A_CMP) begin
      cmp_q <= '0;
      cmp_q[CMP_LO +: CMP_W]    <= reg_wdata[CMP_LO +: CMP_W];
      cmp_q[KEEP_HI:KEEP_LO]    <= reg_wdata[KEEP_HI:KEEP_LO];
    end
  end
  assign src_offset = cmp_q[CMP_LO +: CMP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= |bad;
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_B0]   = status[0];
    ctrl_word[CTRL_B0-1] = status[1];
    stat_word = '0;
    for (int k = 0; k < N_STAT; k++) stat_word[STAT_HI-k] = status[k+2];
  end

  always_comb begin
    reg_rdata = '1;
    if (slot[SRC_W]) begin
      reg_rdata = vec_pack(vecs[slot[SRC_W-1:0]], pend[slot[SRC_W-1:0]]);
    end else begin
      case (reg_addr)
        A_CTRL:  reg_rdata = ctrl_word;
        A_STAT:  reg_rdata = stat_word;
        A_CMP:   reg_rdata = cmp_q;
        default: reg_rdata = '1;
      endcase
    end
  end

  always_comb begin
    route_server = '0;
    route_prio   = '0;
    route_src    = '0;
    if (route_sel < SRC_W'(NUM_VEC)) begin
      route_server = srv_strip(vecs[route_sel].server);
      route_prio   = vecs[route_sel].prio;
      route_src    = vecs[route_sel].src;
    end
  end

  AST_SHARED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] || status[1]) |-> line_out[vecs[0].src]); // R4
  AST_MASK_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_VEC0 && vecs[0].prio == '1) |-> !reg_rdata[PEND_B]); // R5
  AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_CMP) |=> $stable(src_offset)); // R9
endmodule

// File: tb/sim_vec_irq_router.sv
module sim_vec_irq_router;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  irq_in = '0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [2:0]  route_sel = '0;
  logic [13:0] route_server;
  logic [7:0]  route_prio;
  logic [2:0]  route_src;
  logic [7:0]  line_out;
  logic [18:0] src_offset;
  logic        wr_err;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_router u0 (.*);

  // stimulus irq pattern and expected lines under default routing
  localparam logic [14:0] TABLE [10] = '{
    {7'b0000000, 8'b00000000},
    {7'b0000001, 8'b00000001},
    {7'b0000010, 8'b00000001},
    {7'b0000011, 8'b00000001},
    {7'b0000100, 8'b00000010},
    {7'b0001000, 8'b00000100},
    {7'b0010000, 8'b00001000},
    {7'b0100000, 8'b00010000},
    {7'b1000000, 8'b00100000},
    {7'b1010101, 8'b00101011}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive(logic [6:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  function automatic logic [5:0] vaddr(int i);
    return (i == 0) ? 6'h10 : 6'(6'h15 + i);
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [63:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(vaddr(i), d);
      check("R1 vector init", d, (64'hFF << 32) | (64'(i) << 29));
    end
    rd(6'h0E, d); check("R1 ctrl", d, 64'h0);
    rd(6'h15, d); check("R1 stat", d, 64'h0);
    rd(6'h1B, d); check("R1 cmp", d, 64'h0);
    check("R1 lines", 64'(line_out), 64'h0);

    // table walk: R2 R3
    for (int t = 0; t < 10; t++) begin
      drive(TABLE[t][14:8]);
      check("R3 line table", 64'(line_out), 64'(TABLE[t][7:0]));
      exp = '0;
      exp[47] = TABLE[t][8];
      exp[46] = TABLE[t][9];
      rd(6'h0E, d); check("R2 ctrl bits", d, exp);
      exp = '0;
      for (int k = 0; k < 5; k++) exp[36-k] = TABLE[t][10+k];
      rd(6'h15, d); check("R2 stat bits", d, exp);
    end
    drive(7'b0);

    // R4 shared release order
    drive(7'b0000011);
    drive(7'b0000010);
    check("R4 one shared still set", 64'(line_out[0]), 64'h1);
    drive(7'b0000000);
    check("R4 both clear", 64'(line_out[0]), 64'h0);

    // R5 pending follows mask
    drive(7'b0000001);
    rd(6'h10, d); check("R5 masked no pending", 64'(d[24]), 64'h0);
    wr(6'h10, (64'h1234 << 40) | (64'h05 << 32));
    rd(6'h10, d);
    check("R5 pending set", d, (64'h1234 << 40) | (64'h05 << 32) | (64'h1 << 24));
    route_sel = 3'd0; #1;
    check("R7 server stripped", 64'(route_server), 64'h48D);
    check("R7 prio", 64'(route_prio), 64'h05);
    wr(6'h10, (64'h1234 << 40) | (64'hFF << 32));
    rd(6'h10, d); check("R5 re-masked", 64'(d[24]), 64'h0);
    drive(7'b0);

    // R6 field filtering, R11 remap
    wr(6'h18, 64'hFFFF_FFFF_DFFF_FFFF);
    rd(6'h18, d); check("R6 fields only", d, 64'h00FF_FFFF_C000_0000);
    route_sel = 3'd3; #1;
    check("R7 route server", 64'(route_server), 64'h3FFF);
    check("R7 route src", 64'(route_src), 64'h6);
    route_sel = 3'd7; #1;
    check("R7 out of range", {route_server, route_prio, route_src}, 64'h0);
    drive(7'b0010000);
    check("R11 remapped line", 64'(line_out), 64'h40);
    drive(7'b0);

    // R8 rejected source 7
    wr(6'h16, (64'h7 << 29) | (64'h11 << 32));
    check("R8 err flag", 64'(wr_err), 64'h1);
    rd(6'h16, d); check("R8 unchanged", d, (64'hFF << 32) | (64'h1 << 29));
    @(negedge clk);
    check("R8 err one cycle", 64'(wr_err), 64'h0);

    // R9 compare register
    drive(7'b0000100);
    wr(6'h1B, '1);
    rd(6'h1B, d); check("R9 cmp stored", d, 64'hFFFF_E00F_0000_0000);
    check("R9 offset", 64'(src_offset), 64'h7FFFF);
    check("R9 lines unaffected", 64'(line_out), 64'h02);

    // R10 unmapped read and ignored writes
    rd(6'h00, d); check("R10 unmapped", d, '1);
    wr(6'h15, '0);
    wr(6'h0E, '1);
    rd(6'h15, d); check("R10 stat write ignored", d, 64'h1 << 36);
    rd(6'h0E, d); check("R10 ctrl write ignored", d, 64'h0);
    drive(7'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule